// File: doc/BRIEF.md
# AUX Native Burst Transfer Sequencer

This block moves a burst of bytes to or from the configuration register space of a display sink. It does so by programming a lower AUX channel engine through a small register-style port. A request carries a direction, a 20-bit start address and a byte length. Bytes to be written arrive on an input byte stream. Bytes that are read leave on an output byte stream.

The sequencer cuts the request into chunks of at most 16 bytes. Each chunk is run as one native transaction on the engine, and a chunk that fails is tried again up to a parameterised limit. When the request finishes, the block reports one of three result codes: success, timeout or I/O error. Timeouts are measured in millisecond ticks that arrive on an input.

The controller is a single state machine with these states: Idle, Fill, Clear, AddrLo, AddrMid, AddrHi, Load, Command, Go, WaitEnable, WaitReply, AckReply, Check, ErrClear, Drain, Advance and Finish.

- Idle goes to Finish for a zero-length request, to Fill for a write and to Clear for a read.
- Fill goes to Clear once the chunk's bytes have been taken in.
- Clear, AddrLo and AddrMid step forward in that order. AddrHi then goes to Load for a write or to Command for a read.
- Load goes to Command once the buffer is loaded.
- Command goes to Go, and Go goes to WaitEnable.
- WaitEnable goes to WaitReply once the enable bit reads back as clear.
- WaitReply goes to AckReply once the reply flag is set, and AckReply goes to Check.
- Check goes to ErrClear if the error flag is set, to Drain after a read succeeds, and to Advance after a write succeeds.
- Drain goes to Advance, which goes to Finish after the last chunk and otherwise to Fill or Clear.
- A failed attempt goes back to Clear, or to Finish if it was the last try.
- Finish goes to Idle.

Top module: `auxn_burst_seq`

## Requirements
- R1: A request of length L > 0 is issued as ceil(L/16) chunks. Chunk k starts at the request address plus 16*k and carries min(16, L-16*k) bytes.
- R2: Every attempt writes the engine in this order: buffer clear (select 0), address bits 7:0 (select 1), bits 15:8 (select 2), bits 19:16 (select 3), data bytes for a write (select 7, indexed), command (select 4), then enable (select 5, bit 0). Select 6 is the flags register. The block never reads and writes the engine in the same cycle.
- R3: The command word is {chunk length minus 1 in bits 7:4, bit 3 = 1 for a native transaction, bits 2:1 = 0, bit 0 = 1 for a read and 0 for a write}.
- R4: Write bytes are taken from the input stream once per chunk, in order, and held locally. Every attempt of that chunk loads the same bytes into the engine buffer before the command is issued.
- R5: Read bytes are put on the output stream in address order, one per valid cycle, only after their chunk has succeeded. A request that fails outputs no bytes from its failing chunk.
- R6: Each chunk is attempted at most MAX_TRIES (10) times. When the last attempt fails, the request ends with that attempt's error and no later chunk is issued.
- R7: If the enable bit has not cleared within EN_LIMIT_MS (20) ticks after it is set, the attempt fails with a timeout.
- R8: After enable clears, the block waits up to RP_LIMIT_MS (10) ticks for the reply flag (flags bit 0), or the attempt fails with a timeout. A received reply is cleared by writing 1 to flags bit 0.
- R9: If the error flag (flags bit 1) is set, the block clears it by writing 1 to flags bit 1 and the attempt fails with an I/O error. A nonzero status field (flags bits 7:4) also fails the attempt with an I/O error.
- R10: A zero-length request raises done in the next cycle with success and causes no engine access.
- R11: Each request produces exactly one single-cycle done pulse with a code: 0 for success, 1 for timeout, 2 for I/O error. A request is taken only while req_ready is high, which it is from reset whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_read | input | 1 | 1 = read from the sink, 0 = write to the sink |
| req_addr | input | 20 | Start address in the sink |
| req_len | input | LEN_W | Byte count |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken this cycle |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Request finished (one-cycle pulse) |
| done_code | output | 2 | Result code: 0 ok, 1 timeout, 2 I/O error |
| eng_wr | output | 1 | Engine register write strobe |
| eng_rd | output | 1 | Engine register read strobe |
| eng_sel | output | 3 | Engine register select |
| eng_idx | output | 4 | Data buffer index for select 7 |
| eng_wdata | output | 8 | Engine write data |
| eng_rdata | input | 8 | Engine read data, valid in the same cycle as eng_rd |

## Verification
The assertions assume three things about the inputs. A request is raised only while req_ready is high. The engine returns read data combinationally in the cycle of the read strobe. The enable, reply and error flags change only as a consequence of the block's own register writes. The bench engine model follows these rules: it answers every read from its current register state, and it completes an attempt a few cycles after enable, in a manner (success, error flag, nonzero status, stuck enable or missing reply) chosen per attempt by the test. Requests are raised only at falling edges while req_ready is high, and ms_tick comes from a fixed divider, so the timeouts land in a known window.

// File: rtl/auxn_pkg.sv
package auxn_pkg;

    // Engine data buffer depth; fixed by the engine's 4-bit length field.
    localparam int CHUNK = 16;
    localparam int CIW   = 4;              // buffer index width
    localparam int CW    = 5;              // chunk length width (0..16)

    typedef enum logic [2:0] {
        SEL_BUFCLR   = 3'd0,
        SEL_ADDR_LO  = 3'd1,
        SEL_ADDR_MID = 3'd2,
        SEL_ADDR_HI  = 3'd3,
        SEL_CMD      = 3'd4,
        SEL_CTL      = 3'd5,
        SEL_FLAGS    = 3'd6,
        SEL_DATA     = 3'd7
    } eng_sel_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_TIMEOUT = 2'd1,
        RES_IOERR   = 2'd2
    } result_e;

    typedef enum logic [4:0] {
        S_IDLE, S_FILL, S_CLR, S_AD0, S_AD1, S_AD2, S_LOAD, S_CMD, S_GO,
        S_WEN, S_WRP, S_ACK, S_CHK, S_ECLR, S_DRAIN, S_NEXT, S_FIN
    } seq_state_e;

endpackage

// File: rtl/auxn_ms_timer.sv
module auxn_ms_timer #(
    parameter int LIMIT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic ms_tick,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (ms_tick && cnt_q != W'(LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == W'(LIMIT));

    // Expiry is only ever reached on a millisecond tick (R7, R8).
    assert_tick_expiry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(ms_tick));

endmodule

// File: rtl/auxn_chunk_split.sv
module auxn_chunk_split
    import auxn_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic [LEN_W-1:0] remaining,
    output logic [CW-1:0]    chunk_len,
    output logic             last_chunk
);
    always_comb begin
        last_chunk = (remaining <= LEN_W'(CHUNK));
        chunk_len  = last_chunk ? CW'(remaining) : CW'(CHUNK);
    end
endmodule

// File: rtl/auxn_burst_seq.sv
module auxn_burst_seq
    import auxn_pkg::*;
#(
    parameter int LEN_W       = 8,
    parameter int MAX_TRIES   = 10,
    parameter int EN_LIMIT_MS = 20,
    parameter int RP_LIMIT_MS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_read,
    input  logic [19:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic [1:0]       done_code,
    output logic             eng_wr,
    output logic             eng_rd,
    output logic [2:0]       eng_sel,
    output logic [3:0]       eng_idx,
    output logic [7:0]       eng_wdata,
    input  logic [7:0]       eng_rdata
);
    localparam int TW = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;

    seq_state_e           state_q, state_d;
    logic                 dir_rd_q;
    logic [19:0]          addr_q;
    logic [LEN_W-1:0]     rem_q;
    logic [CIW-1:0]       idx_q;
    logic [TW-1:0]        tries_q;
    result_e              code_q;
    logic                 rd_valid_q;
    logic [7:0]           rd_data_q;
    logic [7:0]           wbuf_q [CHUNK];

    logic [CW-1:0]        clen;
    logic [CIW-1:0]       clen_m1;
    logic                 last_chunk;
    logic                 last_try;
    logic                 en_expired, rp_expired;
    logic                 att_fail, att_ok;
    result_e              fail_code;
    logic [7:0]           cmd_word;

    auxn_chunk_split #(.LEN_W(LEN_W)) split_i (
        .remaining  (rem_q),
        .chunk_len  (clen),
        .last_chunk (last_chunk)
    );

    auxn_ms_timer #(.LIMIT(EN_LIMIT_MS)) en_timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_q == S_GO),
        .ms_tick (ms_tick),
        .expired (en_expired)
    );

    auxn_ms_timer #(.LIMIT(RP_LIMIT_MS)) rp_timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_q == S_WEN),
        .ms_tick (ms_tick),
        .expired (rp_expired)
    );

    assign clen_m1  = CIW'(clen - CW'(1));
    assign last_try = (tries_q == TW'(MAX_TRIES - 1));
    assign cmd_word = {clen_m1, 1'b1, 2'b00, dir_rd_q};

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        req_ready = (state_q == S_IDLE);
        wr_ready  = 1'b0;
        eng_wr    = 1'b0;
        eng_rd    = 1'b0;
        eng_sel   = SEL_BUFCLR;
        eng_idx   = idx_q;
        eng_wdata = 8'h00;
        done      = 1'b0;
        att_fail  = 1'b0;
        att_ok    = 1'b0;
        fail_code = RES_IOERR;
        unique case (state_q)
            S_IDLE: if (req_valid) begin
                if (req_len == '0) state_d = S_FIN;
                else               state_d = req_read ? S_CLR : S_FILL;
            end
            S_FILL: begin
                wr_ready = 1'b1;
                if (wr_valid && idx_q == clen_m1) state_d = S_CLR;
            end
            S_CLR: begin
                eng_wr  = 1'b1;
                eng_sel = SEL_BUFCLR;
                state_d = S_AD0;
            end
            S_AD0: begin
                eng_wr    = 1'b1;
                eng_sel   = SEL_ADDR_LO;
                eng_wdata = addr_q[7:0];
                state_d   = S_AD1;
            end
            S_AD1: begin
                eng_wr    = 1'b1;
                eng_sel   = SEL_ADDR_MID;
                eng_wdata = addr_q[15:8];
                state_d   = S_AD2;
            end
            S_AD2: begin
                eng_wr    = 1'b1;
                eng_sel   = SEL_ADDR_HI;
                eng_wdata = {4'h0, addr_q[19:16]};
                state_d   = dir_rd_q ? S_CMD : S_LOAD;
            end
            S_LOAD: begin
                eng_wr    = 1'b1;
                eng_sel   = SEL_DATA;
                eng_wdata = wbuf_q[idx_q];
                if (idx_q == clen_m1) state_d = S_CMD;
            end
            S_CMD: begin
                eng_wr    = 1'b1;
                eng_sel   = SEL_CMD;
                eng_wdata = cmd_word;
                state_d   = S_GO;
            end
            S_GO: begin
                eng_wr    = 1'b1;
                eng_sel   = SEL_CTL;
                eng_wdata = 8'h01;
                state_d   = S_WEN;
            end
            S_WEN: begin
                eng_rd  = 1'b1;
                eng_sel = SEL_CTL;
                if (!eng_rdata[0]) begin
                    state_d = S_WRP;
                end else if (en_expired) begin
                    att_fail  = 1'b1;
                    fail_code = RES_TIMEOUT;
                end
            end
            S_WRP: begin
                eng_rd  = 1'b1;
                eng_sel = SEL_FLAGS;
                if (eng_rdata[0]) begin
                    state_d = S_ACK;
                end else if (rp_expired) begin
                    att_fail  = 1'b1;
                    fail_code = RES_TIMEOUT;
                end
            end
            S_ACK: begin
                eng_wr    = 1'b1;
                eng_sel   = SEL_FLAGS;
                eng_wdata = 8'h01;
                state_d   = S_CHK;
            end
            S_CHK: begin
                eng_rd  = 1'b1;
                eng_sel = SEL_FLAGS;
                if (eng_rdata[1]) begin
                    state_d = S_ECLR;
                end else if (eng_rdata[7:4] != 4'h0) begin
                    att_fail = 1'b1;
                end else begin
                    att_ok  = 1'b1;
                    state_d = dir_rd_q ? S_DRAIN : S_NEXT;
                end
            end
            S_ECLR: begin
                eng_wr    = 1'b1;
                eng_sel   = SEL_FLAGS;
                eng_wdata = 8'h02;
                att_fail  = 1'b1;
            end
            S_DRAIN: begin
                eng_rd  = 1'b1;
                eng_sel = SEL_DATA;
                if (idx_q == clen_m1) state_d = S_NEXT;
            end
            S_NEXT: begin
                if (last_chunk) state_d = S_FIN;
                else            state_d = dir_rd_q ? S_CLR : S_FILL;
            end
            S_FIN: begin
                done    = 1'b1;
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
        if (att_fail) state_d = last_try ? S_FIN : S_CLR;
    end

    // Datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_rd_q   <= 1'b0;
            addr_q     <= '0;
            rem_q      <= '0;
            idx_q      <= '0;
            tries_q    <= '0;
            code_q     <= RES_OK;
            rd_valid_q <= 1'b0;
            rd_data_q  <= 8'h00;
            for (int i = 0; i < CHUNK; i++) wbuf_q[i] <= 8'h00;
        end else begin
            rd_valid_q <= 1'b0;
            unique case (state_q)
                S_IDLE: if (req_valid) begin
                    dir_rd_q <= req_read;
                    addr_q   <= req_addr;
                    rem_q    <= req_len;
                    idx_q    <= '0;
                    tries_q  <= '0;
                    code_q   <= RES_OK;
                end
                S_FILL: if (wr_valid) begin
                    wbuf_q[idx_q] <= wr_data;
                    idx_q         <= (idx_q == clen_m1) ? '0 : idx_q + 1'b1;
                end
                S_AD2, S_CHK: idx_q <= '0;
                S_LOAD: idx_q <= idx_q + 1'b1;
                S_DRAIN: begin
                    idx_q      <= idx_q + 1'b1;
                    rd_valid_q <= 1'b1;
                    rd_data_q  <= eng_rdata;
                end
                S_NEXT: begin
                    addr_q  <= addr_q + 20'(clen);
                    rem_q   <= rem_q - LEN_W'(clen);
                    tries_q <= '0;
                    idx_q   <= '0;
                end
                default: ;
            endcase
            if (att_ok) code_q <= RES_OK;
            if (att_fail) begin
                code_q <= fail_code;
                if (!last_try) tries_q <= tries_q + 1'b1;
            end
        end
    end

    assign rd_valid  = rd_valid_q;
    assign rd_data   = rd_data_q;
    assign done_code = code_q;

    // A chunk issued to the engine is never empty and never over 16 bytes (R1).
    assert_chunk_size_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CMD) |-> (clen != '0 && clen <= CW'(CHUNK)));

    // Never read and write the engine in the same cycle (R2).
    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_wr && eng_rd));

    // The write byte stream is only pulled during a write request (R4).
    assert_fill_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !dir_rd_q);

    // Read bytes only appear during a read request (R5).
    assert_rd_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> dir_rd_q);

    // A failure on the last allowed try finishes the request next cycle (R6).
    assert_final_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (att_fail && last_try) |=> (done && done_code != RES_OK));

    // Zero-length request completes at once with success (R10).
    assert_zero_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_len == '0) |=> (done && done_code == RES_OK));

    // Done is a single-cycle pulse (R11).
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/auxn_burst_seq_tb_top.sv
module auxn_burst_seq_tb_top;

    localparam int M_OK = 0, M_ERR = 1, M_STAT = 2, M_HANG = 3, M_NORP = 4;
    localparam int TICKP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ms_tick;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_read = 1'b0;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic        wr_valid;
    logic        wr_ready;
    logic [7:0]  wr_data;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        done;
    logic [1:0]  done_code;
    logic        eng_wr, eng_rd;
    logic [2:0]  eng_sel;
    logic [3:0]  eng_idx;
    logic [7:0]  eng_wdata;
    logic [7:0]  eng_rdata;

    always #10 clk = ~clk;   // 50 MHz

    auxn_burst_seq dut_i (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
        .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
        .req_addr(req_addr), .req_len(req_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .done_code(done_code),
        .eng_wr(eng_wr), .eng_rd(eng_rd), .eng_sel(eng_sel), .eng_idx(eng_idx),
        .eng_wdata(eng_wdata), .eng_rdata(eng_rdata)
    );

    int errs = 0, checks = 0;

    function automatic logic [7:0] pat(input logic [19:0] a);
        return (a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C) + {4'h0, a[19:16]};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Millisecond tick divider
    int tick_div = 0;
    always @(posedge clk) tick_div <= (tick_div == TICKP - 1) ? 0 : tick_div + 1;
    assign ms_tick = (tick_div == TICKP - 1);

    // Write byte source: always offers the next byte of a known series
    int wr_pos = 0;
    assign wr_valid = 1'b1;
    assign wr_data  = 8'(wr_pos * 7 + 3);
    always @(posedge clk) if (wr_valid && wr_ready) wr_pos <= wr_pos + 1;

    // Read byte checker
    int rd_pos = 0, rd_bad = 0, rd_ref = 0;
    always @(posedge clk) if (rd_valid) begin
        if (rd_data != pat(20'(rd_ref + rd_pos))) rd_bad <= rd_bad + 1;
        rd_pos <= rd_pos + 1;
    end

    // Behavioural AUX engine
    logic [7:0]  m_buf [16];
    logic [7:0]  m_cmd;
    logic [19:0] m_addr;
    logic        m_en, m_reply, m_err;
    logic [3:0]  m_stat;
    int          m_cnt, m_mode;
    logic [2:0]  seq_mask;
    logic        clr_seen;
    logic [7:0]  sink [1024];
    logic [19:0] addr_log [64];
    logic [7:0]  cmd_log [64];
    int n_att = 0, n_clr = 0, n_strobe = 0, seq_err = 0;
    int att_base = 0, fail_total = 0, fail_mode = M_OK;

    always_comb begin
        case (eng_sel)
            3'd5:    eng_rdata = {7'b0, m_en};
            3'd6:    eng_rdata = {m_stat, 2'b00, m_err, m_reply};
            3'd7:    eng_rdata = m_buf[eng_idx];
            default: eng_rdata = 8'h00;
        endcase
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en <= 1'b0; m_reply <= 1'b0; m_err <= 1'b0; m_stat <= 4'h0;
            m_cnt <= 0; m_mode <= M_OK; m_cmd <= 8'h00; m_addr <= '0;
            seq_mask <= 3'b000; clr_seen <= 1'b0;
            for (int i = 0; i < 16; i++) m_buf[i] <= 8'h00;
        end else begin
            if (eng_wr || eng_rd) n_strobe <= n_strobe + 1;
            if (eng_wr) begin
                case (eng_sel)
                    3'd0: begin
                        for (int i = 0; i < 16; i++) m_buf[i] <= 8'h00;
                        n_clr <= n_clr + 1; seq_mask <= 3'b000; clr_seen <= 1'b1;
                    end
                    3'd1: begin m_addr[7:0]   <= eng_wdata;      seq_mask[0] <= clr_seen; end
                    3'd2: begin m_addr[15:8]  <= eng_wdata;      seq_mask[1] <= seq_mask[0]; end
                    3'd3: begin m_addr[19:16] <= eng_wdata[3:0]; seq_mask[2] <= seq_mask[1]; end
                    3'd4: m_cmd <= eng_wdata;
                    3'd5: begin
                        m_en <= 1'b1; m_cnt <= 3; m_stat <= 4'h0;
                        n_att <= n_att + 1;
                        addr_log[n_att[5:0]] <= m_addr;
                        cmd_log[n_att[5:0]]  <= m_cmd;
                        if (!(clr_seen && seq_mask == 3'b111)) seq_err <= seq_err + 1;
                        clr_seen <= 1'b0; seq_mask <= 3'b000;
                        m_mode <= ((n_att - att_base) < fail_total) ? fail_mode : M_OK;
                    end
                    3'd6: begin
                        if (eng_wdata[0]) m_reply <= 1'b0;
                        if (eng_wdata[1]) m_err <= 1'b0;
                    end
                    default: m_buf[eng_idx] <= eng_wdata;
                endcase
            end
            if (m_en && m_cnt > 0) begin
                m_cnt <= m_cnt - 1;
                if (m_cnt == 1) begin
                    if (m_mode != M_HANG) m_en <= 1'b0;
                    if (m_mode != M_NORP && m_mode != M_HANG) m_reply <= 1'b1;
                    if (m_mode == M_ERR)  m_err <= 1'b1;
                    if (m_mode == M_STAT) m_stat <= 4'h9;
                    if (m_mode == M_OK) begin
                        for (int i = 0; i < 16; i++) begin
                            if (i <= int'(m_cmd[7:4])) begin
                                if (m_cmd[0]) m_buf[i] <= pat(m_addr + 20'(i));
                                else          sink[10'(m_addr + 20'(i))] <= m_buf[i];
                            end
                        end
                    end
                end
            end
        end
    end

    // One request, with the next nfail attempts failing in the given mode
    task automatic run_case(input bit rd, input logic [19:0] a, input int len,
                            input int nfail, input int mode, input int exp_code,
                            input string tag);
        int att0, clr0, wp0, rdp0, rdb0, strb0, exp_att, nch, cyc, bad;
        att0 = n_att; clr0 = n_clr; wp0 = wr_pos; rdp0 = rd_pos; rdb0 = rd_bad;
        strb0 = n_strobe;
        att_base = n_att; fail_total = nfail; fail_mode = mode;
        rd_ref = int'(a) - rd_pos;
        req_read = rd; req_addr = a; req_len = 8'(len); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
        nch = (len + 15) / 16;
        exp_att = (len == 0) ? 0 : (nfail >= 10 ? 10 : nch + nfail);
        chk(done == 1'b1, "R11 done seen", int'(done), 1);
        chk(int'(done_code) == exp_code, tag, int'(done_code), exp_code);
        chk(n_att - att0 == exp_att, "R6 attempt count", n_att - att0, exp_att);
        chk(n_clr - clr0 == exp_att, "R2 buffer clears", n_clr - clr0, exp_att);
        chk(seq_err == 0, "R2 access order", seq_err, 0);
        chk(m_reply == 1'b0, "R8 reply flag cleared", int'(m_reply), 0);
        chk(m_err == 1'b0, "R9 error flag cleared", int'(m_err), 0);
        if (len == 0) begin
            chk(cyc == 1, "R10 zero length latency", cyc, 1);
            chk(n_strobe == strb0, "R10 no engine access", n_strobe - strb0, 0);
        end
        if (exp_code == 0 && nfail == 0 && len > 0) begin
            bad = 0;
            for (int j = 0; j < nch; j++) begin
                int cl;
                cl = (len - 16 * j > 16) ? 16 : len - 16 * j;
                if (addr_log[6'(att0 + j)] != 20'(int'(a) + 16 * j)) bad++;
                if (cmd_log[6'(att0 + j)] != {4'(cl - 1), 1'b1, 2'b00, rd}) bad++;
            end
            chk(bad == 0, "R1 R3 chunk address and command", bad, 0);
        end
        if (exp_code == 0 && len > 0) begin
            if (rd) begin
                chk(rd_pos - rdp0 == len, "R5 read byte count", rd_pos - rdp0, len);
                chk(rd_bad == rdb0, "R5 read byte values", rd_bad - rdb0, 0);
            end else begin
                bad = 0;
                for (int k = 0; k < len; k++)
                    if (sink[10'(int'(a) + k)] != 8'((wp0 + k) * 7 + 3)) bad++;
                chk(bad == 0, "R4 written bytes", bad, 0);
                chk(wr_pos - wp0 == len, "R4 stream bytes taken", wr_pos - wp0, len);
            end
        end
        if (exp_code != 0 && rd)
            chk(rd_pos == rdp0, "R5 no bytes on failure", rd_pos - rdp0, 0);
        @(negedge clk);
        chk(done == 1'b0 && req_ready == 1'b1, "R11 single pulse then idle",
            int'(done), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && done == 1'b0 && rd_valid == 1'b0 && wr_ready == 1'b0,
            "R11 reset state", int'(req_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && !eng_wr && !eng_rd, "R11 idle after reset",
            int'(req_ready), 1);

        run_case(1'b0, 20'h00123, 0, 0, M_OK, 0, "R10 zero length write");
        run_case(1'b1, 20'h00456, 0, 0, M_OK, 0, "R10 zero length read");

        for (int len = 1; len <= 40; len++)
            run_case(1'b0, 20'(32'h0FFF0 + len * 3), len, 0, M_OK, 0, "R1 write sweep");
        for (int len = 1; len <= 40; len++)
            run_case(1'b1, 20'(32'hFFF00 + len * 5), len, 0, M_OK, 0, "R1 read sweep");

        run_case(1'b1, 20'h0A000, 20, 9,  M_ERR,  0, "R6 nine failures then ok");
        run_case(1'b0, 20'h0B000, 20, 10, M_ERR,  2, "R6 R9 error flag exhausts tries");
        run_case(1'b0, 20'h0C000, 33, 2,  M_STAT, 0, "R9 R4 status retry then ok");
        run_case(1'b1, 20'h0D000, 5,  10, M_STAT, 2, "R9 nonzero status fails");
        run_case(1'b1, 20'h0E000, 4,  10, M_HANG, 1, "R7 enable never clears");
        run_case(1'b0, 20'h0F000, 17, 3,  M_HANG, 0, "R7 enable stall then ok");
        run_case(1'b0, 20'h01000, 3,  10, M_NORP, 1, "R8 reply never arrives");
        run_case(1'b1, 20'h02000, 18, 4,  M_NORP, 0, "R8 missing reply then ok");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule